// File: doc/BRIEF.md
# LCD panel power sequencer

This block brings a flat-panel display up and down in a safe order. When the power request goes high, it first turns on the panel supply. After a programmed wait it enables the pixel data and control drivers. After a second wait it turns on the backlight. When the request drops, it undoes the same steps in reverse: backlight off, then data and control off, then supply off. A request that drops while power-up is still running reverses from the step reached so far. It does not finish the power-up first.

The waits are counted in ticks of a slow sequencing clock, nominally 32 Hz. A divider makes this tick from the fast reference clock that the block runs on. Each wait lasts 0 to 7 ticks. One 3-bit field sets the power-up waits and a second 3-bit field sets the power-down waits. A test input replaces the slow tick with one tick per reference cycle, so simulation runs quickly; in normal use this input is held at 0. A select input hands the three enables to external sequencing, which is a bypass intended only for bring-up. Status outputs report fully on, fully off, and whether a power-up or power-down is in progress.

Top module: `lcd_pwr_seq`

## Requirements
- R1: A synchronous active-high reset puts the block in the off state. In that state supply_en, data_en and light_en are 0, panel_off is 1, and panel_on, up_busy and down_busy are 0.
- R2: When pwr_req is seen high in the off state, supply_en rises on the next clock. data_en rises up_delay×P+1 cycles later, and light_en rises a further up_delay×P+1 cycles after that. P is REF_DIV, or 1 in test mode.
- R3: When pwr_req is seen low while the panel is fully on, light_en falls on the next clock. data_en falls down_delay×P+1 cycles later, and supply_en falls a further down_delay×P+1 cycles after that.
- R4: One sequencing tick equals REF_DIV reference cycles. The tick divider restarts on every step change. A wait of 0 keeps a step for exactly one cycle, and a wait of 7 keeps it for 7×REF_DIV+1 cycles.
- R5: When fast_tick_test is 1, every reference cycle is a tick, so a wait of N lasts N+1 cycles.
- R6: If pwr_req is seen low during power-up, the block turns back from the current step. From the supply-only step it goes straight to the final supply-off wait. From the data step it goes to the data-off wait with the backlight still off. It never turns the backlight on.
- R7: Once power-down has started, pwr_req has no effect until the off state is reached. The output timing is the same as for an undisturbed power-down.
- R8: panel_on is 1 only when fully on. panel_off is 1 only when off. up_busy is 1 during the two power-up steps and down_busy is 1 during the two power-down steps. The observed vector {panel_on,panel_off,up_busy,down_busy,light_en,data_en,supply_en} takes these values: 0100000 (off), 0010001 (up, supply only), 0010011 (up, supply and data), 1000111 (on), 0001011 (down, backlight off), 0001001 (down, supply only).
- R9: While seq_ext_sel is 1, the sequencer is held in the off state and pwr_req is ignored. supply_en, data_en and light_en copy ext_supply_en, ext_data_en and ext_light_en one cycle later. When seq_ext_sel first goes high, the outputs switch to the external inputs on the next clock.
- R10: Under internal sequencing, at most one of the three enables changes on any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_req | input | 1 | 1 requests the panel on, 0 requests it off |
| seq_ext_sel | input | 1 | 0 selects internal sequencing, 1 selects external bypass |
| fast_tick_test | input | 1 | 1 replaces the slow tick with one tick per reference cycle |
| up_delay | input | DLY_W | Ticks waited at each power-up step |
| down_delay | input | DLY_W | Ticks waited at each power-down step |
| ext_supply_en | input | 1 | External supply enable, used in bypass |
| ext_data_en | input | 1 | External data/control enable, used in bypass |
| ext_light_en | input | 1 | External backlight enable, used in bypass |
| supply_en | output | 1 | Panel supply enable |
| data_en | output | 1 | Pixel data and control output enable |
| light_en | output | 1 | Backlight enable |
| panel_on | output | 1 | Fully powered |
| panel_off | output | 1 | Fully powered down |
| up_busy | output | 1 | Power-up in progress |
| down_busy | output | 1 | Power-down in progress |

## Verification
Every sequencer state drives a distinct pattern on the three enables and four status flags. A wrong state therefore shows at the ports on the clock edge that enters it. A wrong tick count or a divider that does not restart moves the next step edge by at least one cycle. The bench compares each output change against an expected vector and an absolute cycle number. A bad reversal path shows up as the wrong busy flag on the cycle after the request drops. It can also show up as a backlight edge that should never occur.

// File: rtl/lcdpwr_pkg.sv
package lcdpwr_pkg;

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_UP_SUP = 3'd1,
        ST_UP_DAT = 3'd2,
        ST_ON     = 3'd3,
        ST_DN_DAT = 3'd4,
        ST_DN_SUP = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic light;
        logic data;
        logic supply;
    } rails_t;

    typedef struct packed {
        logic full_on;
        logic full_off;
        logic up_busy;
        logic dn_busy;
    } flags_t;

    function automatic rails_t rails_of(seq_state_e s);
        rails_t r;
        r = '0;
        case (s)
            ST_UP_SUP, ST_DN_SUP: r.supply = 1'b1;
            ST_UP_DAT, ST_DN_DAT: begin
                r.supply = 1'b1;
                r.data   = 1'b1;
            end
            ST_ON: r = '1;
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic is_down(seq_state_e s);
        return (s == ST_DN_DAT) || (s == ST_DN_SUP);
    endfunction

    function automatic logic is_up(seq_state_e s);
        return (s == ST_UP_SUP) || (s == ST_UP_DAT);
    endfunction

    function automatic flags_t flags_of(seq_state_e s);
        flags_t f;
        f.full_on  = (s == ST_ON);
        f.full_off = (s == ST_OFF);
        f.up_busy  = is_up(s);
        f.dn_busy  = is_down(s);
        return f;
    endfunction

endpackage

// File: rtl/lcdpwr_tick_gen.sv
module lcdpwr_tick_gen #(
    parameter int DIV = 447443
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic fast,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] div_cnt;

    assign tick = fast || (div_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart || tick)
            div_cnt <= '0;
        else
            div_cnt <= div_cnt + 1'b1;
    end

    // R4: divider never passes its terminal count
    p_div_bound_r4: assert property (@(posedge clk) disable iff (rst)
        div_cnt <= LAST);

    // R4: a step change restarts the divider
    p_div_restart_r4: assert property (@(posedge clk) disable iff (rst)
        restart |=> div_cnt == '0);

endmodule

// File: rtl/lcdpwr_step_timer.sv
module lcdpwr_step_timer #(
    parameter int DW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          tick,
    input  logic [DW-1:0] limit,
    output logic          done
);
    logic [DW-1:0] cnt;

    assign done = (cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (tick && !done)
            cnt <= cnt + 1'b1;
    end

    // R4: each tick inside a step advances the count by exactly one
    p_tick_step_r4: assert property (@(posedge clk) disable iff (rst)
        (!restart && tick && !done) |=> cnt == $past(cnt) + 1'b1);

    // R4: count is held without a tick
    p_tick_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!restart && !tick) |=> $stable(cnt));

endmodule

// File: rtl/lcdpwr_fsm.sv
module lcdpwr_fsm
    import lcdpwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ext_sel,
    input  logic       req,
    input  logic       done,
    output seq_state_e state,
    output logic       restart
);
    seq_state_e nxt;

    always_comb begin
        nxt = state;
        if (ext_sel) begin
            nxt = ST_OFF;
        end else begin
            case (state)
                ST_OFF:    if (req) nxt = ST_UP_SUP;
                ST_UP_SUP: if (!req) nxt = ST_DN_SUP;
                           else if (done) nxt = ST_UP_DAT;
                ST_UP_DAT: if (!req) nxt = ST_DN_DAT;
                           else if (done) nxt = ST_ON;
                ST_ON:     if (!req) nxt = ST_DN_DAT;
                ST_DN_DAT: if (done) nxt = ST_DN_SUP;
                ST_DN_SUP: if (done) nxt = ST_OFF;
                default:   nxt = ST_OFF;
            endcase
        end
    end

    assign restart = (nxt != state);

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_OFF;
        else
            state <= nxt;
    end

    // R1: reset lands in the off state
    p_rst_off_r1: assert property (@(posedge clk)
        rst |=> state == ST_OFF);

    // R2: supply step completes into the data step
    p_up_order_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_UP_SUP && done && req && !ext_sel) |=> state == ST_UP_DAT);

    // R6: drop during the data step turns back without lighting
    p_abort_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_UP_DAT && !req && !ext_sel) |=> state == ST_DN_DAT);

    // R7: power-down waits regardless of the request
    p_down_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DN_DAT && !done && !ext_sel) |=> state == ST_DN_DAT);

    // R9: bypass pins the sequencer off
    p_ext_off_r9: assert property (@(posedge clk) disable iff (rst)
        ext_sel |=> state == ST_OFF);

endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq
    import lcdpwr_pkg::*;
#(
    parameter int REF_DIV = 447443,
    parameter int DLY_W   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_req,
    input  logic             seq_ext_sel,
    input  logic             fast_tick_test,
    input  logic [DLY_W-1:0] up_delay,
    input  logic [DLY_W-1:0] down_delay,
    input  logic             ext_supply_en,
    input  logic             ext_data_en,
    input  logic             ext_light_en,
    output logic             supply_en,
    output logic             data_en,
    output logic             light_en,
    output logic             panel_on,
    output logic             panel_off,
    output logic             up_busy,
    output logic             down_busy
);
    seq_state_e       state;
    logic             restart;
    logic             tick;
    logic             done;
    logic [DLY_W-1:0] limit;
    logic             ext_sel_q;
    rails_t           ext_q;
    rails_t           rails;
    flags_t           flags;

    assign limit = is_down(state) ? down_delay : up_delay;

    lcdpwr_tick_gen #(.DIV(REF_DIV)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .fast    (fast_tick_test),
        .tick    (tick)
    );

    lcdpwr_step_timer #(.DW(DLY_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .tick    (tick),
        .limit   (limit),
        .done    (done)
    );

    lcdpwr_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .ext_sel (seq_ext_sel),
        .req     (pwr_req),
        .done    (done),
        .state   (state),
        .restart (restart)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_sel_q <= 1'b0;
            ext_q     <= '0;
        end else begin
            ext_sel_q <= seq_ext_sel;
            ext_q     <= '{light: ext_light_en, data: ext_data_en, supply: ext_supply_en};
        end
    end

    assign rails     = ext_sel_q ? ext_q : rails_of(state);
    assign flags     = flags_of(state);
    assign supply_en = rails.supply;
    assign data_en   = rails.data;
    assign light_en  = rails.light;
    assign panel_on  = flags.full_on;
    assign panel_off = flags.full_off;
    assign up_busy   = flags.up_busy;
    assign down_busy = flags.dn_busy;

    // R2: under internal control the backlight needs data and data needs supply
    p_rail_order_r2: assert property (@(posedge clk) disable iff (rst)
        !ext_sel_q |-> ((!light_en || data_en) && (!data_en || supply_en)));

    // R8: fully-on flag agrees with all enables
    p_on_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (panel_on && !ext_sel_q) |-> (supply_en && data_en && light_en));

    // R8: status flags are mutually exclusive
    p_flags_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({panel_on, panel_off, up_busy, down_busy}));

    // R10: only one enable moves per edge when sequencing internally
    p_one_rail_r10: assert property (@(posedge clk) disable iff (rst)
        (!ext_sel_q && !seq_ext_sel) |=>
            $countones({supply_en, data_en, light_en} ^
                       $past({supply_en, data_en, light_en})) <= 1);

    // R9: bypass copies the external enables one cycle later
    p_ext_follow_r9: assert property (@(posedge clk) disable iff (rst)
        seq_ext_sel |=> {supply_en, data_en, light_en} ==
                        $past({ext_supply_en, ext_data_en, ext_light_en}));

endmodule

// File: tb/lcd_pwr_seq_test.sv
module lcd_pwr_seq_test;

    localparam int DIV = 4;

    localparam logic [6:0] V_OFF = 7'b0100000;
    localparam logic [6:0] V_UPS = 7'b0010001;
    localparam logic [6:0] V_UPD = 7'b0010011;
    localparam logic [6:0] V_ON  = 7'b1000111;
    localparam logic [6:0] V_DND = 7'b0001011;
    localparam logic [6:0] V_DNS = 7'b0001001;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwr_req = 1'b0;
    logic       seq_ext_sel = 1'b0;
    logic       fast_tick_test = 1'b0;
    logic [2:0] up_delay = 3'd0;
    logic [2:0] down_delay = 3'd0;
    logic       ext_supply_en = 1'b0;
    logic       ext_data_en = 1'b0;
    logic       ext_light_en = 1'b0;
    logic       supply_en, data_en, light_en;
    logic       panel_on, panel_off, up_busy, down_busy;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int per    = DIV;
    logic finished = 1'b0;

    logic [6:0] exp_vec_q[$];
    int         exp_cyc_q[$];
    string      exp_tag_q[$];

    logic [6:0] obs, prev;

    lcd_pwr_seq #(.REF_DIV(DIV), .DLY_W(3)) uut (
        .clk            (clk),
        .rst            (rst),
        .pwr_req        (pwr_req),
        .seq_ext_sel    (seq_ext_sel),
        .fast_tick_test (fast_tick_test),
        .up_delay       (up_delay),
        .down_delay     (down_delay),
        .ext_supply_en  (ext_supply_en),
        .ext_data_en    (ext_data_en),
        .ext_light_en   (ext_light_en),
        .supply_en      (supply_en),
        .data_en        (data_en),
        .light_en       (light_en),
        .panel_on       (panel_on),
        .panel_off      (panel_off),
        .up_busy        (up_busy),
        .down_busy      (down_busy)
    );

    always #2.5 clk = ~clk;

    assign obs = {panel_on, panel_off, up_busy, down_busy, light_en, data_en, supply_en};

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops and compares each observed output change
    always @(negedge clk) begin
        if (!rst && obs !== prev) begin
            checks++;
            if (exp_vec_q.size() == 0) begin
                fails++;
                $display("FAIL unexpected change at cycle %0d: actual %b expected no change", cyc, obs);
            end else begin
                automatic logic [6:0] ev = exp_vec_q.pop_front();
                automatic int         ec = exp_cyc_q.pop_front();
                automatic string      et = exp_tag_q.pop_front();
                if (obs !== ev || cyc != ec) begin
                    fails++;
                    $display("FAIL %s: actual %b at cycle %0d, expected %b at cycle %0d",
                             et, obs, cyc, ev, ec);
                end
            end
        end
        prev <= obs;
    end

    function automatic int gap(int n);
        return n * per + 1;
    endfunction

    task automatic push(string tag, logic [6:0] v, int at);
        exp_tag_q.push_back(tag);
        exp_vec_q.push_back(v);
        exp_cyc_q.push_back(at);
    endtask

    task automatic wait_until(int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic go_up(int a, string tag);
        int t;
        @(negedge clk);
        up_delay = 3'(a);
        pwr_req  = 1'b1;
        t = cyc + 1;
        push(tag, V_UPS, t);
        t += gap(a);
        push(tag, V_UPD, t);
        t += gap(a);
        push(tag, V_ON, t);
        wait_until(t + 2);
    endtask

    task automatic go_down(int b, string tag);
        int t;
        @(negedge clk);
        down_delay = 3'(b);
        pwr_req    = 1'b0;
        t = cyc + 1;
        push(tag, V_DND, t);
        t += gap(b);
        push(tag, V_DNS, t);
        t += gap(b);
        push(tag, V_OFF, t);
        wait_until(t + 2);
    endtask

    task automatic direct(string tag, logic [6:0] ev);
        checks++;
        if (obs !== ev) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, obs, ev);
        end
    endtask

    task automatic drained(string tag);
        checks++;
        if (exp_vec_q.size() != 0) begin
            fails++;
            $display("FAIL %s: actual %0d pending events expected 0", tag, exp_vec_q.size());
            exp_vec_q.delete();
            exp_cyc_q.delete();
            exp_tag_q.delete();
        end
    endtask

    initial begin
        int k;
        int t;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        direct("R1 reset", V_OFF);

        // R2 R3 R8 R10: nominal up then down
        go_up(2, "R2 R8 R10 up");
        go_down(1, "R3 R8 down");
        drained("R2 R3");

        // R4: boundary waits
        go_up(0, "R4 up wait0");
        go_down(0, "R4 down wait0");
        go_up(7, "R4 up wait7");
        go_down(7, "R4 down wait7");
        drained("R4");

        // R5: test mode tick every cycle
        @(negedge clk);
        fast_tick_test = 1'b1;
        per = 1;
        go_up(3, "R5 up fast");
        go_down(5, "R5 down fast");
        @(negedge clk);
        fast_tick_test = 1'b0;
        per = DIV;
        drained("R5");

        // R6: drop in the data step
        @(negedge clk);
        up_delay = 3'd2;
        down_delay = 3'd2;
        pwr_req = 1'b1;
        k = cyc;
        push("R6 data-step abort", V_UPS, k + 1);
        push("R6 data-step abort", V_UPD, k + 1 + gap(2));
        wait_until(k + 12);
        pwr_req = 1'b0;
        t = k + 13;
        push("R6 data-step abort", V_DND, t);
        t += gap(2);
        push("R6 data-step abort", V_DNS, t);
        t += gap(2);
        push("R6 data-step abort", V_OFF, t);
        wait_until(t + 2);
        drained("R6 data-step");

        // R6: drop in the supply step
        @(negedge clk);
        pwr_req = 1'b1;
        k = cyc;
        push("R6 supply-step abort", V_UPS, k + 1);
        wait_until(k + 3);
        pwr_req = 1'b0;
        t = k + 4;
        push("R6 supply-step abort", V_DNS, t);
        t += gap(2);
        push("R6 supply-step abort", V_OFF, t);
        wait_until(t + 2);
        drained("R6 supply-step");

        // R7: request pulse during power-down is ignored
        go_up(1, "R7 setup up");
        @(negedge clk);
        down_delay = 3'd3;
        pwr_req = 1'b0;
        k = cyc;
        t = k + 1;
        push("R7 down ignores req", V_DND, t);
        t += gap(3);
        push("R7 down ignores req", V_DNS, t);
        t += gap(3);
        push("R7 down ignores req", V_OFF, t);
        wait_until(k + 3);
        pwr_req = 1'b1;
        wait_until(k + 5);
        pwr_req = 1'b0;
        wait_until(t + 2);
        drained("R7");

        // R9: external bypass, request ignored
        @(negedge clk);
        seq_ext_sel = 1'b1;
        wait_until(cyc + 3);
        direct("R9 bypass idle", V_OFF);
        k = cyc;
        pwr_req = 1'b1;
        ext_supply_en = 1'b1;
        push("R9 bypass supply", 7'b0100001, k + 1);
        wait_until(k + 4);
        ext_data_en  = 1'b1;
        ext_light_en = 1'b1;
        push("R9 bypass all", 7'b0100111, k + 5);
        wait_until(k + 8);
        ext_supply_en = 1'b0;
        ext_data_en   = 1'b0;
        ext_light_en  = 1'b0;
        pwr_req       = 1'b0;
        push("R9 bypass release", V_OFF, k + 9);
        wait_until(k + 11);
        seq_ext_sel = 1'b0;
        wait_until(k + 14);
        drained("R9");

        // R1: reset while fully on
        go_up(0, "R1 setup up");
        @(negedge clk);
        rst = 1'b1;
        pwr_req = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        direct("R1 reset from on", V_OFF);
        repeat (3) @(negedge clk);
        drained("R1");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule